// File: doc/BRIEF.md
# SPI Slave Boot Image Loader

This block is the boot front end of a processor. When reset is released it reads three strap pins once and chooses a boot source from them. If the straps select SPI slave boot, the block waits for an external SPI master to frame an image with its chip select. It shifts the image in bit by bit and writes each completed byte into on-chip RAM through a byte-wide write port, at consecutive addresses starting from zero. Any other strap setting only reports the chosen source on `boot_mode`, and the SPI pins are then left alone.

The SPI pins are asynchronous to the system clock. They pass through two-flop synchronizers, and edges are found on the synchronized copies, so SCLK may run at no more than a quarter of the system clock. The image is framed by chip select alone; there is no length field and no checksum. When chip select rises at the end of the image, the block raises a sticky `boot_done` and presents the entry address at which the core starts executing. SPI activity during a settle window that follows reset is ignored. An image larger than the RAM sets an overflow flag, and the bytes beyond the RAM are not written.

Top module: `spi_boot_loader`

## Requirements
- R1: On `strap` (index 2 = pin bit6, index 1 = pin bit5, index 0 = pin bit4), the value 3'b010 selects SPI boot and `boot_mode` = 2'b01. A value with `strap[2:1]` = 2'b00 selects flash boot and `boot_mode` = 2'b00. Every other value gives `boot_mode` = 2'b10.
- R2: The straps are latched on the first clock after reset is released. Later changes on `strap` do not change `boot_mode` until the next reset.
- R3: In SPI mode 0, MOSI is sampled on the rising edge of SCLK, and each byte arrives least significant bit first. The n-th complete byte of an image (counting from 0) is written with a one-cycle `ram_we` pulse at `ram_addr` = n, with `ram_wdata` = the byte.
- R4: Capture starts only on a falling edge of `spi_cs_n`, and SCLK edges while chip select is high write nothing. The rising edge of chip select ends the image, sets `boot_done` and puts ENTRY_ADDR on `boot_entry`.
- R5: A byte left incomplete when chip select rises is discarded and never written.
- R6: SPI activity during the first SETTLE_CYCLES clocks after reset release is ignored. It writes nothing and does not set `boot_done`.
- R7: `boot_done` stays set until reset. Once it is set, further SPI traffic writes nothing.
- R8: A complete byte arriving after DEPTH bytes have been written sets a sticky `img_overflow` and is not written. Chip select rising still sets `boot_done`.
- R9: In flash or other boot mode (`boot_mode` != 2'b01), SPI traffic writes nothing and `boot_done` stays 0.
- R10: During reset, `ram_we`, `boot_done`, `img_overflow` and `boot_entry` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 3 | Boot-mode strap pins (bit6, bit5, bit4) |
| spi_sclk | input | 1 | SPI serial clock from the master, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the master |
| ram_we | output | 1 | Byte write strobe to on-chip RAM |
| ram_addr | output | $clog2(DEPTH) | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| boot_done | output | 1 | Sticky: the image has been received and the core may start |
| boot_mode | output | 2 | Latched boot source: 00 flash, 01 SPI, 10 other |
| boot_entry | output | $clog2(DEPTH) | Start address, valid while boot_done is set |
| img_overflow | output | 1 | Sticky: the image was larger than the RAM |

## Verification
The bench builds the loader with DEPTH = 16, SETTLE_CYCLES = 200 and ENTRY_ADDR = 5. The small depth lets an image of eighteen bytes run past the end of the RAM, so the overflow boundary is checked both at exactly DEPTH bytes and one byte beyond. The short settle window is longer than one SPI byte time, which means a whole framed byte can be sent inside the window and shown to be ignored. The nonzero entry address makes `boot_entry` distinguishable from its reset value.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  typedef enum logic [1:0] {
    BM_FLASH = 2'b00,
    BM_SPI   = 2'b01,
    BM_OTHER = 2'b10
  } boot_mode_e;

  typedef enum logic [2:0] {
    ST_SETTLE = 3'd0,
    ST_ARMED  = 3'd1,
    ST_RECV   = 3'd2,
    ST_DONE   = 3'd3,
    ST_PARKED = 3'd4
  } ldr_state_e;

  // strap[2] = bit6, strap[1] = bit5, strap[0] = bit4
  function automatic boot_mode_e decode_strap(input logic [2:0] s);
    if (s == 3'b010)       return BM_SPI;
    else if (s[2:1] == 2'b00) return BM_FLASH;
    else                   return BM_OTHER;
  endfunction

  // shift in one bit, least significant bit first
  function automatic logic [7:0] lsb_shift(input logic [7:0] acc, input logic b);
    return {b, acc[7:1]};
  endfunction

  function automatic logic slot_free(input int unsigned used, input int unsigned depth);
    return used < depth;
  endfunction

endpackage

// File: rtl/spi_boot_sync.sv
module spi_boot_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= RST_VAL;
      s2   <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      s1   <= d;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign q    = s2;
  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;
endmodule

// File: rtl/spi_boot_shift.sv
module spi_boot_shift
  import spi_boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       shift_en,
  input  logic       din,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  logic [7:0] acc;
  logic [2:0] nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      nbits <= '0;
    end else if (clear) begin
      nbits <= '0;
    end else if (shift_en) begin
      acc   <= lsb_shift(acc, din);
      nbits <= nbits + 3'd1;
    end
  end

  assign byte_valid = shift_en && !clear && (nbits == 3'd7);
  assign byte_data  = lsb_shift(acc, din);
endmodule

// File: rtl/spi_boot_ctrl.sv
module spi_boot_ctrl
  import spi_boot_pkg::*;
#(
  parameter int unsigned DEPTH         = 4096,
  parameter int unsigned SETTLE_CYCLES = 100000,
  parameter int unsigned ENTRY_ADDR    = 0,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1,
  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    strap,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          shift_clear,
  output logic          in_recv,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          boot_done,
  output logic [1:0]    boot_mode,
  output logic [AW-1:0] boot_entry,
  output logic          img_overflow,
  output logic          settled,
  output logic          strap_locked
);
  ldr_state_e state;
  boot_mode_e mode_q;
  logic [SW-1:0] settle_cnt;
  logic [CW-1:0] byte_cnt;
  logic          room;

  assign settled     = (settle_cnt == SW'(SETTLE_CYCLES));
  assign room        = slot_free(32'(byte_cnt), DEPTH);
  assign in_recv     = (state == ST_RECV);
  assign shift_clear = (state != ST_RECV);
  assign boot_mode   = mode_q;

  // strap latch and settle window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= BM_FLASH;
      strap_locked <= 1'b0;
      settle_cnt   <= '0;
    end else begin
      if (!strap_locked) begin
        mode_q       <= decode_strap(strap);
        strap_locked <= 1'b1;
      end
      if (!settled) settle_cnt <= settle_cnt + SW'(1);
    end
  end

  // framing and RAM write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_SETTLE;
      ram_we       <= 1'b0;
      ram_addr     <= '0;
      ram_wdata    <= '0;
      boot_done    <= 1'b0;
      boot_entry   <= '0;
      img_overflow <= 1'b0;
      byte_cnt     <= '0;
    end else begin
      ram_we <= 1'b0;
      unique case (state)
        ST_SETTLE: begin
          if (settled && strap_locked)
            state <= (mode_q == BM_SPI) ? ST_ARMED : ST_PARKED;
        end
        ST_ARMED: begin
          if (cs_fall) state <= ST_RECV;
        end
        ST_RECV: begin
          if (cs_rise) begin
            state      <= ST_DONE;
            boot_done  <= 1'b1;
            boot_entry <= AW'(ENTRY_ADDR);
          end else if (byte_valid) begin
            if (room && !img_overflow) begin
              ram_we    <= 1'b1;
              ram_addr  <= byte_cnt[AW-1:0];
              ram_wdata <= byte_data;
              byte_cnt  <= byte_cnt + CW'(1);
            end else begin
              img_overflow <= 1'b1;
            end
          end
        end
        ST_DONE:   state <= ST_DONE;
        ST_PARKED: state <= ST_PARKED;
        default:   state <= ST_PARKED;
      endcase
    end
  end
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import spi_boot_pkg::*;
#(
  parameter int unsigned DEPTH         = 4096,
  parameter int unsigned SETTLE_CYCLES = 100000,
  parameter int unsigned ENTRY_ADDR    = 0,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    strap,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          boot_done,
  output logic [1:0]    boot_mode,
  output logic [AW-1:0] boot_entry,
  output logic          img_overflow
);
  // named internal events, visible to the bound checker
  logic [2:0] pin_q, pin_rise, pin_fall;
  logic       cs_rise, cs_fall, sclk_rise, mosi_q;
  logic       shift_clear, in_recv, shift_en;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       settled, strap_locked;

  // {cs_n, sclk, mosi}; chip select resets high
  spi_boot_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_cs_n, spi_sclk, spi_mosi}),
    .q    (pin_q),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign cs_rise   = pin_rise[2];
  assign cs_fall   = pin_fall[2];
  assign sclk_rise = pin_rise[1];
  assign mosi_q    = pin_q[0];
  assign shift_en  = in_recv && sclk_rise;

  spi_boot_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (shift_clear),
    .shift_en  (shift_en),
    .din       (mosi_q),
    .byte_valid(byte_valid),
    .byte_data (byte_data)
  );

  spi_boot_ctrl #(
    .DEPTH        (DEPTH),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .ENTRY_ADDR   (ENTRY_ADDR)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap       (strap),
    .cs_rise     (cs_rise),
    .cs_fall     (cs_fall),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .shift_clear (shift_clear),
    .in_recv     (in_recv),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .boot_done   (boot_done),
    .boot_mode   (boot_mode),
    .boot_entry  (boot_entry),
    .img_overflow(img_overflow),
    .settled     (settled),
    .strap_locked(strap_locked)
  );
endmodule

// File: rtl/spi_boot_chk.sv
module spi_boot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ram_we,
  input logic       boot_done,
  input logic [1:0] boot_mode,
  input logic       img_overflow,
  input logic       cs_rise,
  input logic       settled,
  input logic       strap_locked
);
  // R2: latched mode never moves once locked
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strap_locked |=> $stable(boot_mode));

  // R6: nothing written inside the settle window
  p_quiet_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> !ram_we);

  // R4: boot_done rises only after a chip-select rising edge
  p_done_on_cs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_done) |-> $past(cs_rise));

  // R7: sticky done, and no writes once done
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  p_no_write_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !ram_we);

  // R8: no write after the overflow flag is up
  p_no_overflow_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    img_overflow |-> !ram_we);

  // R9: writes and done only in SPI boot mode
  p_write_spi_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (boot_mode == 2'b01));
  p_done_spi_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (boot_mode == 2'b01));
endmodule

bind spi_boot_loader spi_boot_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ram_we      (ram_we),
  .boot_done   (boot_done),
  .boot_mode   (boot_mode),
  .img_overflow(img_overflow),
  .cs_rise     (cs_rise),
  .settled     (settled),
  .strap_locked(strap_locked)
);

// File: tb/sim_spi_boot_loader.sv
module sim_spi_boot_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int SETTLE     = 200;
  localparam int ENTRY      = 5;
  localparam int AW         = $clog2(DEPTH);
  localparam int HALF_SCLK  = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] strap = 3'b010;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic ram_we, boot_done, img_overflow;
  logic [AW-1:0] ram_addr, boot_entry;
  logic [7:0] ram_wdata;
  logic [1:0] boot_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_boot_loader #(.DEPTH(DEPTH), .SETTLE_CYCLES(SETTLE), .ENTRY_ADDR(ENTRY)) u0 (
    .clk(clk), .rst_n(rst_n), .strap(strap),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .boot_done(boot_done), .boot_mode(boot_mode),
    .boot_entry(boot_entry), .img_overflow(img_overflow)
  );

  int n_checks = 0;
  int n_fail = 0;
  int n_writes = 0;
  int next_addr = 0;
  string cur_req = "R10";
  logic [15:0] exp_q[$];   // {addr, data}

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      n_writes++;
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, "unexpected RAM write {addr,data}",
              {16'd0, 8'(ram_addr), ram_wdata}, 32'hFFFF_FFFF);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({8'(ram_addr), ram_wdata} == e, cur_req, "RAM write {addr,data}",
              {16'd0, 8'(ram_addr), ram_wdata}, {16'd0, e});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] s);
    rst_n = 1'b0; strap = s; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
    wait_clk(4);
    // R10: reset state
    check(ram_we == 1'b0 && boot_done == 1'b0 && img_overflow == 1'b0 && boot_entry == '0,
          "R10", "reset outputs {we,done,ovf,entry}",
          {ram_we, boot_done, img_overflow, 8'(boot_entry)}, 32'd0);
    exp_q.delete(); next_addr = 0; n_writes = 0;
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic spi_bit(input logic b);
    spi_mosi = b;
    wait_clk(HALF_SCLK);
    spi_sclk = 1'b1;
    wait_clk(HALF_SCLK);
    spi_sclk = 1'b0;
  endtask

  // driver: pushes the expected write, then shifts the byte out LSB first
  task automatic send_byte(input logic [7:0] b, input bit expect_wr);
    if (expect_wr && next_addr < DEPTH) begin
      exp_q.push_back({8'(next_addr), b});
      next_addr++;
    end
    for (int i = 0; i < 8; i++) spi_bit(b[i]);
  endtask

  task automatic cs_low();  spi_cs_n = 1'b0; wait_clk(HALF_SCLK); endtask
  task automatic cs_high(); wait_clk(HALF_SCLK); spi_cs_n = 1'b1; wait_clk(8); endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // ---------- SPI boot session ----------
    do_reset(3'b010);
    check(boot_mode == 2'b01, "R1", "boot_mode for strap 010", 32'(boot_mode), 32'd1);
    strap = 3'b000;
    wait_clk(3);
    check(boot_mode == 2'b01, "R2", "boot_mode after strap change", 32'(boot_mode), 32'd1);

    // R6: a full framed byte inside the settle window is ignored
    cur_req = "R6";
    cs_low(); send_byte(8'hC3, 1'b0); cs_high();
    check(boot_done == 1'b0, "R6", "boot_done after settle-window traffic", 32'(boot_done), 32'd0);
    wait_clk(SETTLE);

    // R4: SCLK toggling with chip select high writes nothing
    cur_req = "R4";
    send_byte(8'h5A, 1'b0);
    wait_clk(8);
    check(n_writes == 0 && boot_done == 1'b0, "R4", "writes with CS high",
          32'(n_writes), 32'd0);

    // R3: image of four bytes, then a partial byte (R5)
    cur_req = "R3";
    cs_low();
    send_byte(8'h01, 1'b1);
    send_byte(8'h80, 1'b1);
    send_byte(8'h3C, 1'b1);
    send_byte(8'hA5, 1'b1);
    cur_req = "R5";
    spi_bit(1'b1); spi_bit(1'b0); spi_bit(1'b1);
    check(boot_done == 1'b0, "R4", "boot_done before CS rise", 32'(boot_done), 32'd0);
    cs_high();
    check(exp_q.size() == 0, "R3", "expected writes outstanding", 32'(exp_q.size()), 32'd0);
    check(n_writes == 4, "R5", "write count with trailing partial byte", 32'(n_writes), 32'd4);
    check(boot_done == 1'b1, "R4", "boot_done after CS rise", 32'(boot_done), 32'd1);
    check(boot_entry == AW'(ENTRY), "R4", "boot_entry", 32'(boot_entry), 32'(ENTRY));

    // R7: traffic after done is ignored, done stays
    cur_req = "R7";
    cs_low(); send_byte(8'hFF, 1'b0); send_byte(8'h12, 1'b0); cs_high();
    check(n_writes == 4, "R7", "writes after boot_done", 32'(n_writes), 32'd4);
    check(boot_done == 1'b1, "R7", "boot_done sticky", 32'(boot_done), 32'd1);

    // ---------- overflow session ----------
    do_reset(3'b010);
    wait_clk(SETTLE);
    cur_req = "R8";
    cs_low();
    for (int k = 0; k < DEPTH; k++) send_byte(8'(8'h40 + k), 1'b1);
    wait_clk(6);
    check(img_overflow == 1'b0, "R8", "overflow at exactly DEPTH bytes", 32'(img_overflow), 32'd0);
    check(n_writes == DEPTH, "R8", "writes at DEPTH bytes", 32'(n_writes), 32'(DEPTH));
    send_byte(8'hEE, 1'b1);
    wait_clk(6);
    check(img_overflow == 1'b1, "R8", "overflow after DEPTH+1 bytes", 32'(img_overflow), 32'd1);
    send_byte(8'hDD, 1'b1);
    cs_high();
    check(n_writes == DEPTH, "R8", "writes after overflow", 32'(n_writes), 32'(DEPTH));
    check(boot_done == 1'b1 && img_overflow == 1'b1, "R8", "{done,ovf} after CS rise",
          {boot_done, img_overflow}, 32'd3);

    // ---------- non-SPI sessions (R9) ----------
    for (int m = 0; m < 3; m++) begin
      logic [2:0] s;
      logic [1:0] em;
      s  = (m == 0) ? 3'b000 : (m == 1) ? 3'b100 : 3'b011;
      em = (m == 0) ? 2'b00 : 2'b10;
      do_reset(s);
      check(boot_mode == em, "R1", $sformatf("boot_mode for strap %b", s),
            32'(boot_mode), 32'(em));
      wait_clk(SETTLE);
      cur_req = "R9";
      cs_low(); send_byte(8'h77, 1'b0); send_byte(8'h88, 1'b0); cs_high();
      check(n_writes == 0, "R9", "writes in non-SPI mode", 32'(n_writes), 32'd0);
      check(boot_done == 1'b0, "R9", "boot_done in non-SPI mode", 32'(boot_done), 32'd0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule